// File: doc/BRIEF.md
# Ethernet Controller Status and Configuration Registers

This block is the host-visible register file of an Ethernet controller. The host reaches it through two locations. One is a small pointer register that selects one of four internal registers. The other is a data port that reads or writes the selected register. The four registers are a control/status word, the low and high halves of a 24-bit initialization-block address, and a three-bit bus options word.

The status word holds the controller's event flags. Each flag is set by a one-cycle strobe from the controller core and is cleared when the host writes a one to it. The same word holds the run-control bits. Writing a one to one of these bits issues a one-cycle command pulse to the core (start, stop, initialize, transmit demand). Two summary bits, an error summary and an interrupt summary, are computed from the flags. The interrupt output is the interrupt summary gated by a host-writable enable bit.

The address and options registers can only be changed while the controller is stopped. When an initialize command is taken, the current 24-bit address is latched onto a dedicated output for the core.

Top module: `netc_csr_regs`

## Requirements
- R1: After synchronous reset the status word reads 0x0004 (only the stop bit, bit 2, set). The address and option registers read 0, the pointer reads 0, `irq`, all command pulses, `init_addr` and `bus_opts` are 0.
- R2: A write with `host_sel_ptr`=1 stores `host_wdata[1:0]` as the pointer (0 status word, 1 address low, 2 address high, 3 options). A read with `host_sel_ptr`=1 returns the pointer zero-extended. A data-port access (`host_sel_ptr`=0) goes to the selected register.
- R3: Each core event sets its own status bit on the next edge: babble bit 14, collision bit 13, missed frame bit 12, memory error bit 11, receive done bit 10, transmit done bit 9, init acknowledge bit 8. A set bit stays until the host writes 1 to it. An event arriving in the same cycle as the clearing write leaves the bit set.
- R4: Bit 15 reads as the OR of bits 14:11. Bit 7 reads as the OR of bit 15 and bits 10:8. Bit 6 is a plain read/write enable. `irq` equals bit 7 AND bit 6.
- R5: Data writes to the address and option registers are ignored while the stop bit is 0.
- R6: The address-low register stores all 16 bits. The address-high register stores bits 7:0 and reads bits 15:8 as 0. The options register stores bits 2:0, reads the rest as 0, and drives `bus_opts`.
- R7: Writing 1 to bit 0 (initialize) sets bit 0 and clears the stop bit. On the next edge it drives `cmd_init` high for exactly one cycle, with `init_addr` loaded as {address-high[7:0], address-low}.
- R8: Writing 1 to bit 1 (start) sets bit 1 and the receive-on (bit 5) and transmit-on (bit 4) flags, clears the stop bit, and pulses `cmd_start` for one cycle.
- R9: Writing 1 to bit 2 (stop) sets the stop bit, clears bits 5, 4, 3, 1 and 0, and pulses `cmd_stop`. In the same write it overrides start and initialize, so neither of their pulses appears.
- R10: Writing 1 to bit 3 (transmit demand) while bit 4 is 1 sets bit 3 and pulses `cmd_tx_demand`. Bit 3 clears on a transmit-done event or on stop. While bit 4 is 0 the write has no effect.
- R11: Writes of 1 to the read-only bits 15, 7, 5 and 4 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_sel_ptr | input | 1 | 1 selects the pointer register, 0 the data port |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Combinational read data for the current selection |
| evt_rx_done | input | 1 | Core: frame received |
| evt_tx_done | input | 1 | Core: frame transmitted |
| evt_init_ack | input | 1 | Core: initialization complete |
| evt_miss | input | 1 | Core: receive frame lost |
| evt_mem_err | input | 1 | Core: memory access error |
| evt_collision | input | 1 | Core: collision error |
| evt_babble | input | 1 | Core: transmit too long |
| cmd_start | output | 1 | One-cycle start command |
| cmd_stop | output | 1 | One-cycle stop command |
| cmd_init | output | 1 | One-cycle initialize command |
| cmd_tx_demand | output | 1 | One-cycle transmit poll command |
| init_addr | output | 24 | Latched initialization-block address |
| bus_opts | output | 3 | Bus option bits |
| irq | output | 1 | Interrupt request |

## Verification
The bench looks for the places where the three kinds of status bits mix in one write. In one write it sets stop and start together, and it writes ones onto read-only and write-one-to-clear positions alongside command bits. A design that let start win would show receive-on still set and a start pulse. A design that stored written ones into summary or run flags would read back a changed word. It also lines up a clearing write with a new event of the same kind, which a clear-first design would lose. It tries configuration writes while running, which an unlocked design would accept, and a transmit demand while stopped, which a careless design would pulse. It also checks that the enable bit masks the interrupt while the flag itself is still visible to the host.

// File: rtl/netc_csr_pkg.sv
package netc_csr_pkg;

    localparam int REG_W   = 16;
    localparam int PTR_W   = 2;
    localparam int IADDR_W = 24;
    localparam int HI_W    = IADDR_W - REG_W;
    localparam int OPT_W   = 3;
    localparam int EVT_N   = 7;

    // Bit positions of the status word; the host decodes these.
    localparam int B_ERR  = 15;
    localparam int B_BABL = 14;
    localparam int B_IDON = 8;
    localparam int B_INTR = 7;
    localparam int B_INEA = 6;
    localparam int B_RXON = 5;
    localparam int B_TXON = 4;
    localparam int B_TDMD = 3;
    localparam int B_STOP = 2;
    localparam int B_STRT = 1;
    localparam int B_INIT = 0;

    typedef enum logic [PTR_W-1:0] {
        SEL_STAT    = 2'd0,
        SEL_ADDR_LO = 2'd1,
        SEL_ADDR_HI = 2'd2,
        SEL_OPTS    = 2'd3
    } csr_sel_e;

    // Field order equals status bits 14 down to 8.
    typedef struct packed {
        logic babble;
        logic coll;
        logic miss;
        logic merr;
        logic rx_done;
        logic tx_done;
        logic init_ack;
    } core_evt_t;

    // Field order equals status bits 6 down to 0.
    typedef struct packed {
        logic inea;
        logic rxon;
        logic txon;
        logic tdmd;
        logic stop;
        logic strt;
        logic init;
    } run_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic init;
        logic tx_demand;
    } core_cmd_t;

    typedef struct packed {
        logic             wr;
        csr_sel_e         sel;
        logic [REG_W-1:0] data;
    } host_wr_t;

    function automatic logic [REG_W-1:0] pack_stat(core_evt_t ev, run_state_t rs);
        logic err_sum;
        logic int_sum;
        err_sum = ev.babble | ev.coll | ev.miss | ev.merr;
        int_sum = err_sum | ev.rx_done | ev.tx_done | ev.init_ack;
        return {err_sum, ev, int_sum, rs};
    endfunction

endpackage

// File: rtl/netc_csr_access.sv
module netc_csr_access
    import netc_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic             host_sel_ptr,
    input  logic [REG_W-1:0] host_wdata,
    output csr_sel_e         ptr_q,
    output host_wr_t         data_wr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= SEL_STAT;
        end else if (host_wr && host_sel_ptr) begin
            ptr_q <= csr_sel_e'(host_wdata[PTR_W-1:0]);
        end
    end

    always_comb begin
        data_wr.wr   = host_wr & ~host_sel_ptr;
        data_wr.sel  = ptr_q;
        data_wr.data = host_wdata;
    end

endmodule

// File: rtl/netc_csr_status.sv
module netc_csr_status
    import netc_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  host_wr_t         data_wr,
    input  core_evt_t        evt,
    output core_evt_t        ev_q,
    output run_state_t       rs_q,
    output core_cmd_t        cmd_q,
    output logic             init_take
);

    logic             stat_we;
    logic [REG_W-1:0] ones;
    logic             stop_req;
    logic             strt_req;
    logic             init_req;
    logic             tdmd_req;
    core_evt_t        ev_clr;
    core_evt_t        ev_d;
    run_state_t       rs_d;
    core_cmd_t        cmd_d;

    always_comb begin
        stat_we  = data_wr.wr && (data_wr.sel == SEL_STAT);
        ones     = stat_we ? data_wr.data : '0;
        stop_req = ones[B_STOP];
        strt_req = ones[B_STRT] & ~stop_req;
        init_req = ones[B_INIT] & ~stop_req;
        tdmd_req = ones[B_TDMD] & ~stop_req & rs_q.txon;
        init_take = init_req;

        // New events beat a clearing write in the same cycle.
        ev_clr = core_evt_t'(ones[B_BABL:B_IDON]);
        ev_d   = (ev_q & ~ev_clr) | evt;

        rs_d = rs_q;
        if (stat_we)     rs_d.inea = data_wr.data[B_INEA];
        if (evt.tx_done) rs_d.tdmd = 1'b0;
        if (tdmd_req)    rs_d.tdmd = 1'b1;
        if (strt_req) begin
            rs_d.strt = 1'b1;
            rs_d.stop = 1'b0;
            rs_d.rxon = 1'b1;
            rs_d.txon = 1'b1;
        end
        if (init_req) begin
            rs_d.init = 1'b1;
            rs_d.stop = 1'b0;
        end
        if (stop_req) begin
            rs_d.stop = 1'b1;
            rs_d.strt = 1'b0;
            rs_d.init = 1'b0;
            rs_d.tdmd = 1'b0;
            rs_d.rxon = 1'b0;
            rs_d.txon = 1'b0;
        end

        cmd_d.start     = strt_req;
        cmd_d.stop      = stop_req;
        cmd_d.init      = init_req;
        cmd_d.tx_demand = tdmd_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_q    <= '0;
            rs_q    <= '0;
            rs_q.stop <= 1'b1;
            cmd_q   <= '0;
        end else begin
            ev_q    <= ev_d;
            rs_q    <= rs_d;
            cmd_q   <= cmd_d;
        end
    end

endmodule

// File: rtl/netc_csr_cfg.sv
module netc_csr_cfg
    import netc_csr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  host_wr_t           data_wr,
    input  logic               stopped,
    input  logic               init_take,
    output logic [REG_W-1:0]   addr_lo,
    output logic [HI_W-1:0]    addr_hi,
    output logic [OPT_W-1:0]   opts,
    output logic [IADDR_W-1:0] init_addr
);

    logic cfg_we;

    assign cfg_we = data_wr.wr & stopped;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_lo   <= '0;
            addr_hi   <= '0;
            opts      <= '0;
            init_addr <= '0;
        end else begin
            if (cfg_we) begin
                case (data_wr.sel)
                    SEL_ADDR_LO: addr_lo <= data_wr.data;
                    SEL_ADDR_HI: addr_hi <= data_wr.data[HI_W-1:0];
                    SEL_OPTS:    opts    <= data_wr.data[OPT_W-1:0];
                    default:     ;
                endcase
            end
            if (init_take) begin
                init_addr <= {addr_hi, addr_lo};
            end
        end
    end

endmodule

// File: rtl/netc_csr_regs.sv
module netc_csr_regs
    import netc_csr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic               host_sel_ptr,
    input  logic [REG_W-1:0]   host_wdata,
    output logic [REG_W-1:0]   host_rdata,
    input  logic               evt_rx_done,
    input  logic               evt_tx_done,
    input  logic               evt_init_ack,
    input  logic               evt_miss,
    input  logic               evt_mem_err,
    input  logic               evt_collision,
    input  logic               evt_babble,
    output logic               cmd_start,
    output logic               cmd_stop,
    output logic               cmd_init,
    output logic               cmd_tx_demand,
    output logic [IADDR_W-1:0] init_addr,
    output logic [OPT_W-1:0]   bus_opts,
    output logic               irq
);

    csr_sel_e         ptr_q;
    host_wr_t         data_wr;
    core_evt_t        evt;
    core_evt_t        ev_q;
    run_state_t       rs_q;
    core_cmd_t        cmd_q;
    logic             init_take;
    logic [REG_W-1:0] addr_lo;
    logic [HI_W-1:0]  addr_hi;
    logic [OPT_W-1:0] opts;
    logic [REG_W-1:0] stat_word;
    logic [REG_W-1:0] sel_word;

    always_comb begin
        evt.babble   = evt_babble;
        evt.coll     = evt_collision;
        evt.miss     = evt_miss;
        evt.merr     = evt_mem_err;
        evt.rx_done  = evt_rx_done;
        evt.tx_done  = evt_tx_done;
        evt.init_ack = evt_init_ack;
    end

    netc_csr_access u_access (
        .clk          (clk),
        .rst          (rst),
        .host_wr      (host_wr),
        .host_sel_ptr (host_sel_ptr),
        .host_wdata   (host_wdata),
        .ptr_q        (ptr_q),
        .data_wr      (data_wr)
    );

    netc_csr_status u_status (
        .clk       (clk),
        .rst       (rst),
        .data_wr   (data_wr),
        .evt       (evt),
        .ev_q      (ev_q),
        .rs_q      (rs_q),
        .cmd_q     (cmd_q),
        .init_take (init_take)
    );

    netc_csr_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .data_wr   (data_wr),
        .stopped   (rs_q.stop),
        .init_take (init_take),
        .addr_lo   (addr_lo),
        .addr_hi   (addr_hi),
        .opts      (opts),
        .init_addr (init_addr)
    );

    assign stat_word = pack_stat(ev_q, rs_q);

    always_comb begin
        case (ptr_q)
            SEL_STAT:    sel_word = stat_word;
            SEL_ADDR_LO: sel_word = addr_lo;
            SEL_ADDR_HI: sel_word = REG_W'(addr_hi);
            default:     sel_word = REG_W'(opts);
        endcase
        host_rdata = host_sel_ptr ? REG_W'(ptr_q) : sel_word;
    end

    assign cmd_start     = cmd_q.start;
    assign cmd_stop      = cmd_q.stop;
    assign cmd_init      = cmd_q.init;
    assign cmd_tx_demand = cmd_q.tx_demand;
    assign bus_opts      = opts;
    assign irq           = stat_word[B_INTR] & rs_q.inea;

endmodule

// File: rtl/netc_csr_regs_chk.sv
module netc_csr_regs_chk
    import netc_csr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               host_wr,
    input logic               host_sel_ptr,
    input logic [REG_W-1:0]   host_wdata,
    input logic [PTR_W-1:0]   ptr_q,
    input logic [REG_W-1:0]   stat_word,
    input logic [REG_W-1:0]   addr_lo,
    input logic [HI_W-1:0]    addr_hi,
    input logic [OPT_W-1:0]   opts,
    input logic               evt_rx_done,
    input logic               cmd_start,
    input logic               cmd_stop,
    input logic               cmd_init,
    input logic               cmd_tx_demand,
    input logic [IADDR_W-1:0] init_addr,
    input logic               irq
);

    logic rst_d;
    logic stat_wr;

    always_ff @(posedge clk) rst_d <= rst;

    assign stat_wr = host_wr && !host_sel_ptr && (ptr_q == PTR_W'(0));

    always_ff @(posedge clk) begin
        if (rst_d) begin
            assert_reset_state_R1: assert (stat_word == 16'h0004 && addr_lo == '0 &&
                addr_hi == '0 && opts == '0 && ptr_q == '0 && !irq && !cmd_start &&
                !cmd_stop && !cmd_init && !cmd_tx_demand);
        end
    end

    assert_rx_event_R3: assert property (@(posedge clk) disable iff (rst)
        evt_rx_done |=> stat_word[10]);

    assert_irq_gate_R4: assert property (@(posedge clk) disable iff (rst)
        !stat_word[B_INEA] |-> !irq);

    assert_cfg_locked_R5: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !host_sel_ptr && ptr_q != PTR_W'(0) && !stat_word[B_STOP])
        |=> ($stable(addr_lo) && $stable(addr_hi) && $stable(opts)));

    assert_init_addr_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_init |-> (init_addr == {$past(addr_hi), $past(addr_lo)}));

    assert_stop_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && host_wdata[B_STOP]) |=> (stat_word[B_STOP] && !stat_word[B_RXON] &&
        !stat_word[B_TXON] && cmd_stop && !cmd_start && !cmd_init));

    assert_start_stop_excl_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_start, cmd_stop}));

    assert_tdmd_needs_tx_R10: assert property (@(posedge clk) disable iff (rst)
        cmd_tx_demand |-> $past(stat_word[B_TXON]));

endmodule

bind netc_csr_regs netc_csr_regs_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .host_wr       (host_wr),
    .host_sel_ptr  (host_sel_ptr),
    .host_wdata    (host_wdata),
    .ptr_q         (ptr_q),
    .stat_word     (stat_word),
    .addr_lo       (addr_lo),
    .addr_hi       (addr_hi),
    .opts          (opts),
    .evt_rx_done   (evt_rx_done),
    .cmd_start     (cmd_start),
    .cmd_stop      (cmd_stop),
    .cmd_init      (cmd_init),
    .cmd_tx_demand (cmd_tx_demand),
    .init_addr     (init_addr),
    .irq           (irq)
);

// File: tb/netc_csr_regs_bench.sv
module netc_csr_regs_bench;

    localparam int CLK_P = 10;

    localparam logic [1:0] K_PTR = 2'd0;
    localparam logic [1:0] K_DAT = 2'd1;
    localparam logic [1:0] K_CHK = 2'd2;
    localparam logic [1:0] K_EVT = 2'd3;
    localparam int NVEC = 38;

    // {kind, requirement number, write value or event mask, expected read}
    // event mask: bit0 rx, bit1 tx, bit2 init ack, bit3 miss, bit4 mem err, bit5 collision, bit6 babble
    localparam logic [37:0] VEC [NVEC] = '{
        {K_PTR, 4'd2,  16'h0001, 16'h0000},
        {K_DAT, 4'd6,  16'h1234, 16'h0000},
        {K_CHK, 4'd6,  16'h0000, 16'h1234},   // R6 full low half
        {K_PTR, 4'd2,  16'h0002, 16'h0000},
        {K_DAT, 4'd6,  16'hAB56, 16'h0000},
        {K_CHK, 4'd6,  16'h0000, 16'h0056},   // R6 reserved byte reads 0
        {K_PTR, 4'd2,  16'h0003, 16'h0000},
        {K_DAT, 4'd6,  16'hFFFF, 16'h0000},
        {K_CHK, 4'd6,  16'h0000, 16'h0007},   // R6 options width
        {K_DAT, 4'd6,  16'h0002, 16'h0000},
        {K_CHK, 4'd6,  16'h0000, 16'h0002},
        {K_PTR, 4'd2,  16'h0000, 16'h0000},
        {K_DAT, 4'd11, 16'h80B0, 16'h0000},
        {K_CHK, 4'd11, 16'h0000, 16'h0004},   // R11 read-only bits untouched
        {K_DAT, 4'd7,  16'h0041, 16'h0000},
        {K_CHK, 4'd7,  16'h0000, 16'h0041},   // R7 init set, stop cleared
        {K_EVT, 4'd3,  16'h0004, 16'h0000},
        {K_CHK, 4'd3,  16'h0000, 16'h01C1},   // R3 init ack flag, R4 summary
        {K_DAT, 4'd8,  16'h0142, 16'h0000},
        {K_CHK, 4'd8,  16'h0000, 16'h0073},   // R8 run flags on, flag cleared
        {K_PTR, 4'd2,  16'h0001, 16'h0000},
        {K_DAT, 4'd5,  16'hFFFF, 16'h0000},
        {K_CHK, 4'd5,  16'h0000, 16'h1234},   // R5 locked while running
        {K_PTR, 4'd2,  16'h0000, 16'h0000},
        {K_EVT, 4'd4,  16'h0008, 16'h0000},
        {K_CHK, 4'd4,  16'h0000, 16'h90F3},   // R4 error summary
        {K_DAT, 4'd3,  16'h1040, 16'h0000},
        {K_CHK, 4'd3,  16'h0000, 16'h0073},   // R3 write-one clear
        {K_DAT, 4'd10, 16'h0048, 16'h0000},
        {K_CHK, 4'd10, 16'h0000, 16'h007B},   // R10 demand accepted
        {K_EVT, 4'd10, 16'h0002, 16'h0000},
        {K_CHK, 4'd10, 16'h0000, 16'h02F3},   // R10 demand cleared by tx done
        {K_DAT, 4'd9,  16'h0006, 16'h0000},
        {K_CHK, 4'd9,  16'h0000, 16'h0284},   // R9 stop over start
        {K_EVT, 4'd3,  16'h0071, 16'h0000},
        {K_CHK, 4'd4,  16'h0000, 16'hEE84},   // R4 mixed error sources
        {K_DAT, 4'd3,  16'h7F04, 16'h0000},
        {K_CHK, 4'd3,  16'h0000, 16'h0004}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic        host_sel_ptr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [6:0]  evt_bus = '0;
    logic        cmd_start, cmd_stop, cmd_init, cmd_tx_demand;
    logic [23:0] init_addr;
    logic [2:0]  bus_opts;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    netc_csr_regs u_netc_csr_regs (
        .clk           (clk),
        .rst           (rst),
        .host_wr       (host_wr),
        .host_sel_ptr  (host_sel_ptr),
        .host_wdata    (host_wdata),
        .host_rdata    (host_rdata),
        .evt_rx_done   (evt_bus[0]),
        .evt_tx_done   (evt_bus[1]),
        .evt_init_ack  (evt_bus[2]),
        .evt_miss      (evt_bus[3]),
        .evt_mem_err   (evt_bus[4]),
        .evt_collision (evt_bus[5]),
        .evt_babble    (evt_bus[6]),
        .cmd_start     (cmd_start),
        .cmd_stop      (cmd_stop),
        .cmd_init      (cmd_init),
        .cmd_tx_demand (cmd_tx_demand),
        .init_addr     (init_addr),
        .bus_opts      (bus_opts),
        .irq           (irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic host_write(input logic sel, input logic [15:0] val);
        @(negedge clk);
        host_wr      = 1'b1;
        host_sel_ptr = sel;
        host_wdata   = val;
        @(negedge clk);
        host_wr      = 1'b0;
        host_sel_ptr = 1'b0;
    endtask

    task automatic pulse_evt(input logic [6:0] mask);
        @(negedge clk);
        evt_bus = mask;
        @(negedge clk);
        evt_bus = '0;
    endtask

    task automatic read_port(input logic sel, output logic [15:0] val);
        host_sel_ptr = sel;
        #1;
        val = host_rdata;
        host_sel_ptr = 1'b0;
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] rv;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        read_port(1'b0, rv);
        check("R1 status", rv, 32'h0004);
        read_port(1'b1, rv);
        check("R1 pointer", rv, 32'h0);
        check("R1 outputs", {irq, cmd_start, cmd_stop, cmd_init, cmd_tx_demand, bus_opts, init_addr}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i][37:36])
                K_PTR: host_write(1'b1, VEC[i][31:16]);
                K_DAT: host_write(1'b0, VEC[i][31:16]);
                K_EVT: pulse_evt(VEC[i][22:16]);
                default: begin
                    read_port(1'b0, rv);
                    check($sformatf("R%0d vector %0d", VEC[i][35:32], i), rv, 32'(VEC[i][15:0]));
                end
            endcase
        end

        // R7 init pulse and address latch (stopped, lo 0x1234, hi 0x56)
        host_write(1'b0, 16'h0001);
        check("R7 cmd_init", cmd_init, 1);
        check("R7 init_addr", init_addr, 32'h561234);
        @(negedge clk);
        check("R7 one cycle", cmd_init, 0);

        // R8 start pulse
        host_write(1'b0, 16'h0042);
        check("R8 cmd_start", {cmd_start, cmd_stop}, 32'h2);

        // R4 interrupt gating
        pulse_evt(7'h01);
        check("R4 irq on", irq, 1);
        host_write(1'b0, 16'h0000);
        check("R4 irq masked", irq, 0);
        read_port(1'b0, rv);
        check("R4 flag kept", rv[10], 1);

        // R3 event beats clear in the same cycle
        @(negedge clk);
        host_wr = 1'b1; host_sel_ptr = 1'b0; host_wdata = 16'h0440; evt_bus = 7'h01;
        @(negedge clk);
        host_wr = 1'b0; evt_bus = '0;
        read_port(1'b0, rv);
        check("R3 set wins", rv[10], 1);

        // R9 stop overrides start and init
        host_write(1'b0, 16'h0007);
        check("R9 pulses", {cmd_start, cmd_stop, cmd_init}, 32'h2);
        read_port(1'b0, rv);
        check("R9 status", rv, 32'h0484);

        // R10 demand ignored while stopped
        host_write(1'b0, 16'h0408);
        check("R10 no pulse", cmd_tx_demand, 0);
        read_port(1'b0, rv);
        check("R10 status", rv, 32'h0004);

        // R2 pointer read-back
        host_write(1'b1, 16'h0006);
        read_port(1'b1, rv);
        check("R2 pointer low bits", rv, 32'h2);

        // R6 options output
        check("R6 bus_opts", bus_opts, 32'h2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule